// File: doc/BRIEF.md
# Marked-Store Branch Outcome Table

This block precomputes the outcome of data-dependent branches from the values written by stores that software has marked. When such a store commits, a configurable condition is evaluated on its data word. The result goes into a small direct-mapped table, indexed and tagged by the store address. The result is either a taken/not-taken flag or, for an indirect branch, the stored word taken as a call target.

Later, a branch that software has flagged is looked up with a *predicted* load address. The predicted address is used because the real load address is usually not known yet when the branch is fetched. The block answers one cycle later with a hit indication, a direction and a target. On a miss the hit output stays low, and the surrounding front end uses its history-based predictor instead. A synchronous clear empties the table, for example on a context switch.

Top module: `mst_outcome_table`

## Requirements
- R1: A store with `st_valid`=1 and `st_marked`=0 leaves the table unchanged; a later lookup of that address returns what it returned before.
- R2: A marked store writes the entry selected by word-address bits `st_addr[WLSB+IDX_W-1:WLSB]` (WLSB = log2 of data bytes). It stores the tag `st_addr[WLSB+IDX_W+TAG_W-1:WLSB+IDX_W]` and the evaluated outcome, and marks the entry valid.
- R3: A lookup presented in cycle T yields `pr_valid`=1 in cycle T+1. `pr_hit`=1 only if the selected entry is valid and its tag equals the lookup tag; addresses with equal index and different tag miss.
- R4: The 3-bit mode selects the condition on the signed store word: 0 less than zero, 1 equal to zero, 2 not equal to zero, 3 greater than zero, 4 less than the signed threshold. Mode 5 stores the word as target, with direction taken. Modes 0 to 4 store target 0. With mode 6 or 7, marked stores are ignored.
- R5: In mode 0 every value from -1024 to 1023 is classified correctly: taken exactly when negative.
- R6: If a store and a lookup address the same entry in the same cycle, the lookup returns the contents from before the store. A lookup one cycle later sees the new contents.
- R7: On a miss, `pr_hit`, `pr_taken` and `pr_target` are all zero.
- R8: `clr`=1 invalidates every entry from the next cycle on. A marked store in the same cycle as `clr` is dropped.
- R9: `cfg_we` loads mode and threshold. The new setting applies to stores from the following cycle; a store in the same cycle uses the old setting. Reset loads mode 0 and threshold 0.
- R10: After reset all entries are invalid and `pr_valid` is 0.
- R11: In a cycle after one without a lookup, `pr_valid` and `pr_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous invalidate of all entries |
| cfg_we | input | 1 | Load mode and threshold |
| cfg_mode | input | 3 | Condition code (see R4) |
| cfg_thresh | input | DATA_W | Signed threshold for mode 4 |
| st_valid | input | 1 | A store commits this cycle |
| st_marked | input | 1 | The store carries the tracking hint |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data word |
| lk_valid | input | 1 | Lookup request for a covered branch |
| lk_addr | input | ADDR_W | Predicted load byte address |
| pr_valid | output | 1 | Lookup answer present |
| pr_hit | output | 1 | Entry found; use this outcome |
| pr_taken | output | 1 | Precomputed direction |
| pr_target | output | DATA_W | Precomputed indirect target |

## Verification
The bench builds the block with a 16-bit address and data, 16 entries and a 6-bit tag. With these values a full sweep of the table takes a few dozen cycles, and index-aliasing addresses that differ only in tag are easy to form. The 16-bit data word still holds the whole -1024..1023 range, so the sign test is exercised at both ends and around zero. Same-cycle store/lookup, store/clear and store/configuration collisions are driven on purpose, because these show the read-before-write ordering.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [2:0] {
    CND_NEG  = 3'd0,
    CND_ZERO = 3'd1,
    CND_NZ   = 3'd2,
    CND_POS  = 3'd3,
    CND_LTTH = 3'd4,
    CND_TGT  = 3'd5
  } cond_e;
endpackage

// File: rtl/mst_cfg_reg.sv
module mst_cfg_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_mode,
  input  logic [DATA_W-1:0] cfg_thresh,
  output logic [2:0]        mode_q,
  output logic [DATA_W-1:0] thresh_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 3'd0;
      thresh_q <= '0;
    end else if (cfg_we) begin
      mode_q   <= cfg_mode;
      thresh_q <= cfg_thresh;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(mode_q) && $stable(thresh_q)); // R9
endmodule

// File: rtl/mst_cond_eval.sv
module mst_cond_eval
  import mst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] thresh,
  input  logic [DATA_W-1:0] data,
  output logic              legal,
  output logic              taken,
  output logic [DATA_W-1:0] target
);
  logic signed [DATA_W-1:0] sd, st;
  assign sd = $signed(data);
  assign st = $signed(thresh);

  always_comb begin
    legal  = 1'b1;
    taken  = 1'b0;
    target = '0;
    case (mode)
      CND_NEG:  taken = sd < 0;
      CND_ZERO: taken = (data == '0);
      CND_NZ:   taken = (data != '0);
      CND_POS:  taken = sd > 0;
      CND_LTTH: taken = sd < st;
      CND_TGT: begin
        taken  = 1'b1;
        target = data;
      end
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/mst_table.sv
module mst_table #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 10,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_taken,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_taken,
  output logic [TGT_W-1:0] rd_tgt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = TAG_W + 1 + TGT_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;
  logic [DEPTH-1:0] vld;
  logic             vld_q;
  logic             do_wr;

  assign do_wr = wr_en && !clr;

  // payload array: no reset, read-first, one write and one read port
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_idx] <= {wr_tag, wr_taken, wr_tgt};
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

  // valid bits in flops so a clear takes a single cycle
  always_ff @(posedge clk) begin
    if (rst || clr)  vld <= '0;
    else if (wr_en)  vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld_q <= 1'b0;
    else if (rd_en) vld_q <= vld[rd_idx];
  end

  assign rd_vld                   = vld_q;
  assign {rd_tag, rd_taken, rd_tgt} = rd_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (vld == '0)); // R8
  AST_WRITE_VALIDATES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> vld[$past(wr_idx)]); // R2
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !clr) |=> $stable(vld)); // R1
endmodule

// File: rtl/mst_outcome_table.sv
module mst_outcome_table #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_mode,
  input  logic [DATA_W-1:0] cfg_thresh,
  input  logic              st_valid,
  input  logic              st_marked,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              pr_valid,
  output logic              pr_hit,
  output logic              pr_taken,
  output logic [DATA_W-1:0] pr_target
);
  localparam int WLSB   = $clog2(DATA_W / 8);
  localparam int TAG_LO = WLSB + IDX_W;
  localparam int TAG_HI = TAG_LO + TAG_W - 1;

  logic [2:0]        mode_q;
  logic [DATA_W-1:0] thresh_q;
  logic              c_legal, c_taken;
  logic [DATA_W-1:0] c_target;
  logic              wr_en;
  logic [TAG_W-1:0]  lk_tag_q;
  logic              lk_q;
  logic              e_vld, e_taken;
  logic [TAG_W-1:0]  e_tag;
  logic [DATA_W-1:0] e_tgt;
  logic              hit;
  logic              unused_addr;

  assign unused_addr = ^{st_addr, lk_addr};

  mst_cfg_reg #(.DATA_W(DATA_W)) i_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_thresh(cfg_thresh), .mode_q(mode_q), .thresh_q(thresh_q));

  mst_cond_eval #(.DATA_W(DATA_W)) i_cond (
    .mode(mode_q), .thresh(thresh_q), .data(st_data),
    .legal(c_legal), .taken(c_taken), .target(c_target));

  assign wr_en = st_valid && st_marked && c_legal;

  mst_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(DATA_W)) i_tab (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(wr_en), .wr_idx(st_addr[TAG_LO-1:WLSB]), .wr_tag(st_addr[TAG_HI:TAG_LO]),
    .wr_taken(c_taken), .wr_tgt(c_target),
    .rd_en(lk_valid), .rd_idx(lk_addr[TAG_LO-1:WLSB]),
    .rd_vld(e_vld), .rd_tag(e_tag), .rd_taken(e_taken), .rd_tgt(e_tgt));

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_q     <= 1'b0;
      lk_tag_q <= '0;
    end else begin
      lk_q <= lk_valid;
      if (lk_valid) lk_tag_q <= lk_addr[TAG_HI:TAG_LO];
    end
  end

  assign hit       = lk_q && e_vld && (e_tag == lk_tag_q);
  assign pr_valid  = lk_q;
  assign pr_hit    = hit;
  assign pr_taken  = hit && e_taken;
  assign pr_target = hit ? e_tgt : '0;

  AST_HIT_ONLY_ON_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pr_hit); // R11
  AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pr_hit |-> !pr_taken && (pr_target == '0)); // R7
  AST_UNMARKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !st_marked |-> !wr_en); // R1
  AST_RESERVED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mode_q > 3'd5) |-> !wr_en); // R4
endmodule

// File: tb/test_mst_outcome_table.sv
module test_mst_outcome_table;
  localparam int AW = 16, DW = 16, IW = 4, TW = 6;
  localparam int N = 1 << IW;

  logic clk = 0, rst = 1, clr = 0, cfg_we = 0;
  logic [2:0] cfg_mode = 0;
  logic [DW-1:0] cfg_thresh = 0;
  logic st_valid = 0, st_marked = 0, lk_valid = 0;
  logic [AW-1:0] st_addr = 0, lk_addr = 0;
  logic [DW-1:0] st_data = 0;
  logic pr_valid, pr_hit, pr_taken;
  logic [DW-1:0] pr_target;

  always #2.5 clk = ~clk;

  mst_outcome_table #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .TAG_W(TW)) i_mst_outcome_table (
    .clk(clk), .rst(rst), .clr(clr), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_thresh(cfg_thresh), .st_valid(st_valid), .st_marked(st_marked),
    .st_addr(st_addr), .st_data(st_data), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_taken(pr_taken), .pr_target(pr_target));

  typedef struct {
    logic v, h, t;
    logic [DW-1:0] g;
    string req;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;
  logic m_vld [N];
  logic [TW-1:0] m_tag [N];
  logic m_tk [N];
  logic [DW-1:0] m_tg [N];
  logic [2:0] m_mode = 0;
  logic [DW-1:0] m_th = 0;

  function automatic logic [AW-1:0] mk(input int tag, input int idx);
    return AW'((tag << (IW + 1)) | (idx << 1));
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] a, input logic [DW-1:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, a, e);
    end
  endtask

  // driver: one cycle of stimulus, expected answer pushed to the scoreboard
  task automatic drive(input logic sv, input logic sm, input logic [AW-1:0] sa,
                       input logic [DW-1:0] sd, input logic lv, input logic [AW-1:0] la,
                       input logic c, input logic cw, input logic [2:0] cm,
                       input logic [DW-1:0] ct, input string req);
    exp_t e;
    int li, si;
    logic [TW-1:0] lt, stg;
    logic tk, ok;
    logic [DW-1:0] tg;
    @(negedge clk);
    st_valid = sv; st_marked = sm; st_addr = sa; st_data = sd;
    lk_valid = lv; lk_addr = la; clr = c; cfg_we = cw; cfg_mode = cm; cfg_thresh = ct;
    li = int'(la[IW:1]); lt = la[IW+TW:IW+1];
    e.v = lv; e.req = req;
    e.h = lv && m_vld[li] && (m_tag[li] == lt);
    e.t = e.h && m_tk[li];
    e.g = e.h ? m_tg[li] : '0;
    q.push_back(e);
    ok = 1; tk = 0; tg = '0;
    case (m_mode)
      3'd0: tk = $signed(sd) < 0;
      3'd1: tk = (sd == 0);
      3'd2: tk = (sd != 0);
      3'd3: tk = $signed(sd) > 0;
      3'd4: tk = $signed(sd) < $signed(m_th);
      3'd5: begin tk = 1; tg = sd; end
      default: ok = 0;
    endcase
    si = int'(sa[IW:1]); stg = sa[IW+TW:IW+1];
    if (c) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else if (sv && sm && ok) begin
      m_vld[si] = 1; m_tag[si] = stg; m_tk[si] = tk; m_tg[si] = tg;
    end
    if (cw) begin m_mode = cm; m_th = ct; end
  endtask

  task automatic st(input int tag, input int idx, input logic [DW-1:0] d, input string req);
    drive(1, 1, mk(tag, idx), d, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic lk(input int tag, input int idx, input string req);
    drive(0, 0, 0, 0, 1, mk(tag, idx), 0, 0, 0, 0, req);
  endtask
  task automatic cfg(input logic [2:0] m, input logic [DW-1:0] t, input string req);
    drive(0, 0, 0, 0, 0, 0, 0, 1, m, t, req);
  endtask

  // monitor: pops one expected item per answered cycle
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "pr_valid", DW'(pr_valid), DW'(e.v));
        if (e.v) begin
          chk(e.req, "pr_hit", DW'(pr_hit), DW'(e.h));
          chk(e.req, "pr_taken", DW'(pr_taken), DW'(e.t));
          chk(e.req, "pr_target", pr_target, e.g);
        end else begin
          chk(e.req, "idle pr_hit", DW'(pr_hit), 0);
        end
      end
    end
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_tk[i] = 0; m_tg[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R10", "pr_valid in reset", DW'(pr_valid), 0);
    rst = 0;
    lk(5, 3, "R10");
    lk(0, 0, "R10");
    // sign classification, R5 / R2
    st(1, 1, -16'sd1024, "R5"); st(1, 2, -16'sd1, "R5");
    st(1, 3, 16'd0, "R5");      st(1, 4, 16'd1023, "R5");
    for (int i = 1; i <= 4; i++) lk(1, i, "R5");
    // unmarked store ignored
    drive(1, 0, mk(1, 1), 16'd5, 0, 0, 0, 0, 0, 0, "R1");
    drive(1, 0, mk(2, 6), 16'hffff, 0, 0, 0, 0, 0, 0, "R1");
    lk(1, 1, "R1"); lk(2, 6, "R1");
    // tag aliasing
    lk(2, 1, "R3"); lk(1, 1, "R3");
    // config applies from next cycle
    drive(1, 1, mk(3, 5), 16'd0, 0, 0, 0, 1, 3'd1, 0, "R9");
    st(3, 6, 16'd0, "R9"); st(3, 7, 16'd9, "R4");
    lk(3, 5, "R9"); lk(3, 6, "R9"); lk(3, 7, "R4");
    cfg(3'd2, 0, "R4"); st(4, 8, 16'd7, "R4"); st(4, 9, 16'd0, "R4");
    lk(4, 8, "R4"); lk(4, 9, "R4");
    cfg(3'd3, 0, "R4"); st(4, 8, 16'd1, "R4"); st(4, 9, 16'hffff, "R4");
    lk(4, 8, "R4"); lk(4, 9, "R4");
    cfg(3'd4, 16'd100, "R4");
    st(5, 10, 16'd99, "R4"); st(5, 11, 16'd100, "R4"); st(5, 12, -16'sd5, "R4");
    lk(5, 10, "R4"); lk(5, 11, "R4"); lk(5, 12, "R4");
    cfg(3'd5, 0, "R4"); st(6, 13, 16'h1234, "R4"); lk(6, 13, "R4");
    cfg(3'd6, 0, "R4"); st(6, 14, 16'h0042, "R4"); lk(6, 14, "R4");
    cfg(3'd7, 0, "R4"); st(6, 14, 16'h0043, "R4"); lk(6, 14, "R4");
    // same-cycle store and lookup
    cfg(3'd0, 0, "R6");
    drive(1, 1, mk(1, 1), 16'd5, 1, mk(1, 1), 0, 0, 0, 0, "R6");
    lk(1, 1, "R6");
    // idle cycles
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    // sweep fill and read back
    cfg(3'd3, 0, "R2");
    for (int i = 0; i < N; i++) st(7 + i, i, DW'(i - 8), "R2");
    for (int i = 0; i < N; i++) lk(7 + i, i, "R2");
    for (int i = 0; i < N; i++) lk(8 + i, i, "R7");
    // clear with a colliding store
    drive(1, 1, mk(9, 2), 16'd3, 1, mk(8, 1), 1, 0, 0, 0, "R8");
    for (int i = 0; i < N; i++) lk(7 + i, i, "R8");
    lk(9, 2, "R8");
    repeat (4) @(negedge clk);
    st_valid = 0; lk_valid = 0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule